// File: doc/BRIEF.md
# Programmable SRAM Chip-Enable Decoder

This block produces the active-low chip enable of an external static RAM that shares a bus with an 8-bit processor having a 64 KB address space. It makes the decision from a writable bitmap instead of a fixed address comparator. Each map bit covers one aligned 16-byte block. The map is split into a write half and a read half, and the processor's read/write line picks between them. A block can therefore be mapped for reads only, which makes it behave as ROM. It can also be mapped for writes only, or for both, or be left unmapped.

A host loads the map through a single-bit write port. The port takes the bit index, the bit value and a strobe. Every bus cycle is sampled on the rising clock edge, and the enable for that cycle is driven from a register. Host writes therefore never disturb the enable of a cycle that is already under way. Only the 64 KB window seen by the processor is decoded.

Top module: `sram_select_map`

## Requirements
- R1: After a synchronous reset every map bit is 0. `sram_ce_n` is 1 during reset, and it stays 1 for every bus cycle until the map is programmed.
- R2: The map bit index is {bus_rd, bus_addr[15:4]}. Indices 0..4095 form the write table (bus_rd=0), and indices 4096..8191 form the read table (bus_rd=1). `host_idx` uses the same numbering.
- R3: One map bit governs all 16 addresses of its aligned block. The bits of neighbouring blocks are independent, including across the $7FF0/$8000 boundary.
- R4: A request is sampled at a rising edge. `sram_ce_n` is 0 in the following cycle exactly when bus_valid was 1 and the indexed bit was 1; otherwise it is 1.
- R5: For a block whose read bit is 1 and whose write bit is 0, reads drive `sram_ce_n` low and writes leave it high.
- R6: When bus_valid is 0 at the sampling edge, `sram_ce_n` is 1 in the next cycle regardless of the map contents.
- R7: A host write at an edge changes the map for requests sampled at later edges only. A request sampled at the same edge sees the old bit value. With the bus inputs held and no host write, the enable does not change.
- R8: Writing a 0 through the host port unmaps a block that was previously mapped. Later accesses to that block leave `sram_ce_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; requests are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the map |
| bus_valid | input | 1 | Address phase valid; 0 forces the enable off |
| bus_rd | input | 1 | 1 = processor read, 0 = processor write |
| bus_addr | input | 16 | Processor address |
| host_we | input | 1 | Map write strobe |
| host_idx | input | 13 | Map bit index {dir, block} |
| host_bit | input | 1 | Value written to the indexed map bit |
| sram_ce_n | output | 1 | Active-low SRAM chip enable |

## Verification
On every cycle the assertions check four things:
- the enable is off while reset is active and in the cycle after it;
- the enable follows an invalid address phase by staying high;
- the enable can only be low after a valid sampled request;
- with the bus inputs held and no host write, the enable keeps its value.

The mapping itself can only be shown by the bench's scenarios, because it depends on map contents the properties do not model. These scenarios cover block granularity at the $7FF0/$8000 boundary, the read-only block, the ordering of a host write against a request sampled at the same edge, and unmapping.

// File: rtl/sram_map_pkg.sv
package sram_map_pkg;

    localparam int unsigned CPU_ADDR_W     = 16;
    localparam int unsigned BLOCK_LOG2_DEF = 4;
    localparam int unsigned WORD_LOG2_DEF  = 5;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } bus_dir_e;

    typedef struct packed {
        logic     valid;
        bus_dir_e dir;
    } bus_ctl_t;

    function automatic int unsigned map_index_width(int unsigned addr_w, int unsigned blk_log2);
        return addr_w - blk_log2 + 1;
    endfunction

endpackage

// File: rtl/map_store.sv
module map_store #(
    parameter int unsigned IDX_W     = 13,
    parameter int unsigned WORD_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    localparam int unsigned WORD_W = 2 ** WORD_LOG2;
    localparam int unsigned ROW_W  = IDX_W - WORD_LOG2;
    localparam int unsigned NROWS  = 2 ** ROW_W;

    logic [NROWS-1:0][WORD_W-1:0] rows_flat;
    logic [ROW_W-1:0]             wr_row;
    logic [WORD_LOG2-1:0]         wr_col;
    logic [ROW_W-1:0]             rd_row;
    logic [WORD_LOG2-1:0]         rd_col;
    logic [WORD_W-1:0]            rd_word;

    assign wr_row = wr_idx[IDX_W-1:WORD_LOG2];
    assign wr_col = wr_idx[WORD_LOG2-1:0];
    assign rd_row = rd_idx[IDX_W-1:WORD_LOG2];
    assign rd_col = rd_idx[WORD_LOG2-1:0];

    for (genvar r = 0; r < NROWS; r++) begin : g_row
        logic [WORD_W-1:0] row_q;
        logic              row_sel;

        assign row_sel = wr_en && (wr_row == ROW_W'(r));

        always_ff @(posedge clk) begin
            if (rst) begin
                row_q <= '0;
            end else if (row_sel) begin
                row_q[wr_col] <= wr_bit;
            end
        end

        assign rows_flat[r] = row_q;
    end

    assign rd_word = rows_flat[rd_row];
    assign rd_bit  = rd_word[rd_col];

endmodule

// File: rtl/map_lookup.sv
module map_lookup
    import sram_map_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned BLOCK_LOG2 = 4,
    localparam int unsigned BLK_W     = ADDR_W - BLOCK_LOG2,
    localparam int unsigned IDX_W     = BLK_W + 1
) (
    input  bus_dir_e         dir,
    input  logic [BLK_W-1:0] block,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = {dir == DIR_READ, block};
    end

endmodule

// File: rtl/ce_driver.sv
module ce_driver
    import sram_map_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_ctl_t ctl,
    input  logic     hit,
    output logic     ce_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_n <= 1'b1;
        end else begin
            ce_n <= !(ctl.valid && hit);
        end
    end

endmodule

// File: rtl/sram_select_map.sv
module sram_select_map
    import sram_map_pkg::*;
#(
    parameter int unsigned ADDR_W     = CPU_ADDR_W,
    parameter int unsigned BLOCK_LOG2 = BLOCK_LOG2_DEF,
    parameter int unsigned WORD_LOG2  = WORD_LOG2_DEF,
    localparam int unsigned IDX_W     = map_index_width(ADDR_W, BLOCK_LOG2),
    localparam int unsigned BLK_W     = ADDR_W - BLOCK_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic              host_bit,
    output logic              sram_ce_n
);
    bus_ctl_t         ctl;
    logic [IDX_W-1:0] look_idx;
    logic             map_hit;
    logic             unused_offset;

    assign ctl.valid     = bus_valid;
    assign ctl.dir       = bus_dir_e'(bus_rd);
    assign unused_offset = ^bus_addr[BLOCK_LOG2-1:0];

    map_lookup #(
        .ADDR_W     (ADDR_W),
        .BLOCK_LOG2 (BLOCK_LOG2)
    ) i_lookup (
        .dir   (ctl.dir),
        .block (bus_addr[ADDR_W-1:BLOCK_LOG2]),
        .idx   (look_idx)
    );

    map_store #(
        .IDX_W     (IDX_W),
        .WORD_LOG2 (WORD_LOG2)
    ) i_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (host_we),
        .wr_idx (host_idx),
        .wr_bit (host_bit),
        .rd_idx (look_idx),
        .rd_bit (map_hit)
    );

    ce_driver i_drv (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .hit  (map_hit),
        .ce_n (sram_ce_n)
    );

endmodule

// File: rtl/sram_select_map_chk.sv
module sram_select_map_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              host_we,
    input logic              sram_ce_n
);
    // R1: enable off while reset is active and in the cycle after it
    assert_reset_off_R1: assert property (@(posedge clk) $past(rst) |-> sram_ce_n);

    // R6: an invalid address phase leaves the enable off
    assert_invalid_off_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> sram_ce_n);

    // R4: a low enable requires a valid request at the previous edge
    assert_low_needs_valid_R4: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> $past(bus_valid));

    // R7: held bus inputs with no map update give a steady enable
    assert_steady_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(host_we) && $stable(bus_valid) && $stable(bus_rd)
         && $stable(bus_addr)) |=> $stable(sram_ce_n));

endmodule

bind sram_select_map sram_select_map_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .host_we   (host_we),
    .sram_ce_n (sram_ce_n)
);

// File: tb/test_sram_select_map.sv
module test_sram_select_map;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid;
    logic        bus_rd;
    logic [15:0] bus_addr;
    logic        host_we;
    logic [12:0] host_idx;
    logic        host_bit;
    logic        sram_ce_n;

    bit [8191:0] exp_map;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;

    always #2 clk = ~clk;

    sram_select_map i_sram_select_map (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .host_we   (host_we),
        .host_idx  (host_idx),
        .host_bit  (host_bit),
        .sram_ce_n (sram_ce_n)
    );

    function automatic logic [12:0] idx_of(logic rd, logic [15:0] a);
        return {rd, a[15:4]};
    endfunction

    function automatic logic exp_ce(logic v, logic rd, logic [15:0] a);
        return !(v && exp_map[idx_of(rd, a)]);
    endfunction

    task automatic check(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: sram_ce_n=%0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic host_set(logic [12:0] idx, logic val);
        @(negedge clk);
        host_we  = 1'b1;
        host_idx = idx;
        host_bit = val;
        @(negedge clk);
        host_we  = 1'b0;
        exp_map[idx] = val;
    endtask

    task automatic access(string tag, logic v, logic rd, logic [15:0] a);
        logic e;
        @(negedge clk);
        bus_valid = v;
        bus_rd    = rd;
        bus_addr  = a;
        e = exp_ce(v, rd, a);
        @(negedge clk);
        check(tag, sram_ce_n, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17C0DE));
        exp_map   = '0;
        rst       = 1'b1;
        bus_valid = 1'b1;
        bus_rd    = 1'b1;
        bus_addr  = 16'h0000;
        host_we   = 1'b0;
        host_idx  = '0;
        host_bit  = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", sram_ce_n, 1'b1);
        rst = 1'b0;

        // R1: empty map keeps the chip off
        for (int i = 0; i < 20; i++) begin
            access("R1 unprogrammed", 1'b1, 1'($urandom), 16'($urandom));
        end

        // R2/R3: low 32 KB read/write through both tables
        for (int b = 0; b < 2048; b++) begin
            host_set(13'(b), 1'b1);
            host_set(13'(4096 + b), 1'b1);
        end
        // R5: read-only block at $C010
        host_set(idx_of(1'b1, 16'hC010), 1'b1);

        access("R3 read $7FF0",  1'b1, 1'b1, 16'h7FF0);
        access("R3 read $7FFF",  1'b1, 1'b1, 16'h7FFF);
        access("R3 write $7FF5", 1'b1, 1'b0, 16'h7FF5);
        access("R3 read $8000",  1'b1, 1'b1, 16'h8000);
        access("R3 write $8000", 1'b1, 1'b0, 16'h8000);
        access("R2 write $0000", 1'b1, 1'b0, 16'h0000);
        access("R5 read $C010",  1'b1, 1'b1, 16'hC010);
        access("R5 read $C01F",  1'b1, 1'b1, 16'hC01F);
        access("R5 write $C010", 1'b1, 1'b0, 16'hC010);
        access("R5 write $C01F", 1'b1, 1'b0, 16'hC01F);
        access("R3 read $C020",  1'b1, 1'b1, 16'hC020);
        access("R3 read $C00F",  1'b1, 1'b1, 16'hC00F);
        access("R6 invalid $1000", 1'b0, 1'b1, 16'h1000);
        access("R4 valid $1000",   1'b1, 1'b1, 16'h1000);

        // R7: host write and request sampled at the same edge
        @(negedge clk);
        host_we   = 1'b1;
        host_idx  = idx_of(1'b1, 16'h9000);
        host_bit  = 1'b1;
        bus_valid = 1'b1;
        bus_rd    = 1'b1;
        bus_addr  = 16'h9000;
        @(negedge clk);
        check("R7 same-edge old value", sram_ce_n, 1'b1);
        host_we = 1'b0;
        exp_map[idx_of(1'b1, 16'h9000)] = 1'b1;
        @(negedge clk);
        check("R7 next-edge new value", sram_ce_n, 1'b0);

        // R8: unmapping a block
        host_set(idx_of(1'b1, 16'h7FF0), 1'b0);
        access("R8 unmapped read $7FF8",  1'b1, 1'b1, 16'h7FF8);
        access("R8 write still $7FF8",    1'b1, 1'b0, 16'h7FF8);

        // R4: random mix of map updates and bus cycles
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(7) == 0) begin
                host_set(13'($urandom), 1'($urandom));
            end else begin
                access("R4 random", ($urandom_range(7) != 0), 1'($urandom), 16'($urandom));
            end
        end

        // R1: reset clears the map again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_map = '0;
        access("R1 after reset $0000", 1'b1, 1'b1, 16'h0000);
        access("R1 after reset $C010", 1'b1, 1'b1, 16'hC010);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule